// File: doc/BRIEF.md
# Windowed Rectifier and Integrator

This block sits at the end of a knock-detection signal chain. Signed filtered samples come in with a strobe at the sample rate, nominally 200 kHz, one strobe every 5 µs. Each sample is reduced to its magnitude. While an external integrate window is high, each magnitude is added to a fixed-point accumulator. The weight of each step is the sample period divided by a time constant, and a 5-bit code picks that time constant.

When the window falls, the integer part of the accumulator stays frozen. Software can then read it over the serial port, or a DAC can convert it. Each rising edge of the window restarts the sum from a reset level.

The sum saturates rather than wrapping. A flag records that saturation happened during the current window. The time-constant code is taken only when a window opens, so a change made while a window is running waits for the next one.

Top module: `win_integrator`

## Requirements
- R1: After reset, `resultOut` equals RESET_LEVEL (default 0) and `clampFlag` is 0.
- R2: Each two's-complement sample is reduced to its magnitude. A negative sample and its positive twin give identical results, and -512 counts as magnitude 512.
- R3: Time-constant codes map to µs values as follows:
  - codes 0 to 8 give 40+5·c;
  - codes 9 to 16 give 90+10·(c−9);
  - codes 17 to 24 give 180+20·(c−17);
  - codes 25 to 31 give 360+40·(c−25).
- R4: Coefficient and accumulation rules:
  - The coefficient is round(5·65536/τ).
  - Each counted sample adds floor(|x|·coef/256) to an 18-bit accumulator that has 8 fractional bits.
  - `resultOut` is the accumulator's integer part.
  - It changes on the clock edge that samples the strobe.
- R5: A sample counts only when `sampleStrobe` and `intWindow` are both high in the same cycle.
- R6: While `intWindow` is low, strobes have no effect and `resultOut` holds its value.
- R7: On the first cycle that `intWindow` is high after being low, the accumulator restarts from RESET_LEVEL (integer part, zero fraction).
- R8: The accumulator saturates at integer 1023 with all fractional bits set, and never wraps.
- R9: Once saturation occurs, `clampFlag` stays 1 for the rest of the window and through the hold period. It returns to 0 at the next window start, unless that start cycle itself saturates.
- R10: `tcCode` is captured at each window start. Changes to it during a window do not alter that window's accumulation.
- R11: A strobe in the window-start cycle counts. It is added onto the reset level using the `tcCode` being captured in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sampleIn | input | 10 | Signed filtered sample |
| sampleStrobe | input | 1 | One-cycle pulse marking a new sample |
| intWindow | input | 1 | High = integrate, low = hold |
| tcCode | input | 5 | Time-constant code |
| resultOut | output | 10 | Integer part of the accumulator |
| clampFlag | output | 1 | Saturation occurred in the current window |

## Verification
Two events can land in the same cycle: the window-start restart and the accumulation of a sample. The bench provokes this by raising `intWindow` together with a strobe and a new `tcCode`, right after a window that left a non-zero result.

The result one edge later must equal one increment computed with the new code, added onto the reset level. It must be neither zero (sample dropped) nor the old value plus an increment (restart skipped).

Restart and saturation clearing also meet at the edge that follows a clamped window. There the flag must read 0 immediately after the start.

// File: rtl/win_integ_pkg.sv
package win_integ_pkg;

  localparam int TC_W     = 5;
  localparam int TC_CODES = 1 << TC_W;

  typedef struct packed {
    logic            winStart;
    logic            accumEn;
    logic [TC_W-1:0] tcSel;
  } integCtrl_t;

  // Piecewise time-constant table, in microseconds (R3)
  function automatic int tcMicros(int code);
    if (code <= 8)       return 40 + 5 * code;
    else if (code <= 16) return 90 + 10 * (code - 9);
    else if (code <= 24) return 180 + 20 * (code - 17);
    else                 return 360 + 40 * (code - 25);
  endfunction

  // Rounded fixed-point ratio of sample period to time constant
  function automatic int coefFor(int code, int periodUs, int fracBits);
    int tau;
    tau = tcMicros(code);
    return ((periodUs << fracBits) + tau / 2) / tau;
  endfunction

endpackage

// File: rtl/win_integ_ctrl.sv
module win_integ_ctrl
  import win_integ_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sampleStrobe,
  input  logic            intWindow,
  input  logic [TC_W-1:0] tcCode,
  output integCtrl_t      ctrl
);

  logic            winPrev;
  logic [TC_W-1:0] tcHeld;
  logic            startNow;

  assign startNow = intWindow & ~winPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      winPrev <= 1'b0;
      tcHeld  <= '0;
    end else begin
      winPrev <= intWindow;
      if (startNow) tcHeld <= tcCode;
    end
  end

  always_comb begin
    ctrl.winStart = startNow;
    ctrl.accumEn  = sampleStrobe & intWindow;
    ctrl.tcSel    = startNow ? tcCode : tcHeld;
  end

endmodule

// File: rtl/win_integ_dp.sv
module win_integ_dp
  import win_integ_pkg::*;
#(
  parameter int SAMPLE_W    = 10,
  parameter int FRAC_W      = 8,
  parameter int COEF_FRAC   = 16,
  parameter int PERIOD_US   = 5,
  parameter int RESET_LEVEL = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  integCtrl_t                 ctrl,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  output logic        [SAMPLE_W-1:0] resultOut,
  output logic                       clampFlag
);

  localparam int ACC_W  = SAMPLE_W + FRAC_W;
  localparam int COEF_W = COEF_FRAC + $clog2(PERIOD_US + 1);
  localparam int PROD_W = SAMPLE_W + COEF_W;
  localparam int SHIFT  = COEF_FRAC - FRAC_W;
  localparam int SUM_W  = ACC_W + 2;
  localparam logic [ACC_W-1:0] ACC_MAX   = '1;
  localparam logic [ACC_W-1:0] RESET_ACC = ACC_W'(RESET_LEVEL) << FRAC_W;

  logic [COEF_W-1:0] coefRom [TC_CODES];

  for (genvar g = 0; g < TC_CODES; g++) begin : g_coef
    assign coefRom[g] = COEF_W'(coefFor(g, PERIOD_US, COEF_FRAC));
  end

  logic [SAMPLE_W-1:0] mag;
  logic [PROD_W-1:0]   prod;
  logic [PROD_W-1:0]   incr;
  logic [SUM_W-1:0]    base;
  logic [SUM_W-1:0]    sum;
  logic                overflow;
  logic [ACC_W-1:0]    acc;

  always_comb begin
    mag      = sampleIn[SAMPLE_W-1] ? SAMPLE_W'(-sampleIn) : SAMPLE_W'(sampleIn);
    prod     = PROD_W'(mag) * PROD_W'(coefRom[ctrl.tcSel]);
    incr     = prod >> SHIFT;
    base     = ctrl.winStart ? SUM_W'(RESET_ACC) : SUM_W'(acc);
    sum      = base + (ctrl.accumEn ? SUM_W'(incr) : '0);
    overflow = sum > SUM_W'(ACC_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= RESET_ACC;
      clampFlag <= 1'b0;
    end else begin
      acc       <= overflow ? ACC_MAX : sum[ACC_W-1:0];
      clampFlag <= ctrl.winStart ? overflow : (clampFlag | overflow);
    end
  end

  assign resultOut = acc[ACC_W-1:FRAC_W];

endmodule

// File: rtl/win_integrator.sv
module win_integrator
  import win_integ_pkg::*;
#(
  parameter int SAMPLE_W    = 10,
  parameter int FRAC_W      = 8,
  parameter int COEF_FRAC   = 16,
  parameter int PERIOD_US   = 5,
  parameter int RESET_LEVEL = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic                       sampleStrobe,
  input  logic                       intWindow,
  input  logic [TC_W-1:0]            tcCode,
  output logic [SAMPLE_W-1:0]        resultOut,
  output logic                       clampFlag
);

  integCtrl_t ctrl;

  win_integ_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .sampleStrobe (sampleStrobe),
    .intWindow    (intWindow),
    .tcCode       (tcCode),
    .ctrl         (ctrl)
  );

  win_integ_dp #(
    .SAMPLE_W    (SAMPLE_W),
    .FRAC_W      (FRAC_W),
    .COEF_FRAC   (COEF_FRAC),
    .PERIOD_US   (PERIOD_US),
    .RESET_LEVEL (RESET_LEVEL)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .sampleIn  (sampleIn),
    .resultOut (resultOut),
    .clampFlag (clampFlag)
  );

endmodule

// File: rtl/win_integrator_chk.sv
module win_integrator_chk #(
  parameter int SAMPLE_W    = 10,
  parameter int RESET_LEVEL = 0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sampleStrobe,
  input logic                intWindow,
  input logic [SAMPLE_W-1:0] resultOut,
  input logic                clampFlag
);

  logic winSeen;
  logic openNow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) winSeen <= 1'b0;
    else        winSeen <= intWindow;
  end

  assign openNow = intWindow && !winSeen;

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !intWindow |=> $stable(resultOut));

  assert_no_strobe_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sampleStrobe && !openNow) |=> $stable(resultOut));

  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (openNow && !sampleStrobe) |=> (resultOut == SAMPLE_W'(RESET_LEVEL)) && !clampFlag);

  assert_rises_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (intWindow && !openNow) |=> resultOut >= $past(resultOut));

  assert_clamp_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clampFlag && !openNow) |=> clampFlag);

  assert_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clampFlag) |-> resultOut == '1);

endmodule

bind win_integrator win_integrator_chk #(
  .SAMPLE_W    (SAMPLE_W),
  .RESET_LEVEL (RESET_LEVEL)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sampleStrobe (sampleStrobe),
  .intWindow    (intWindow),
  .resultOut    (resultOut),
  .clampFlag    (clampFlag)
);

// File: tb/win_integrator_bench.sv
module win_integrator_bench;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic signed [9:0] sampleIn = '0;
  logic              sampleStrobe = 1'b0;
  logic              intWindow = 1'b0;
  logic [4:0]        tcCode = '0;
  logic [9:0]        resultOut;
  logic              clampFlag;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  win_integrator u_win_integrator (
    .clk          (clk),
    .rst_n        (rst_n),
    .sampleIn     (sampleIn),
    .sampleStrobe (sampleStrobe),
    .intWindow    (intWindow),
    .tcCode       (tcCode),
    .resultOut    (resultOut),
    .clampFlag    (clampFlag)
  );

  typedef struct packed {
    logic [4:0]        tc;
    logic signed [9:0] smp;
    logic [7:0]        cnt;
    logic [9:0]        expRes;
    logic              expClamp;
  } vec_t;

  // Expected values derived from R3/R4 coefficients: code0=8192, code9=3641,
  // code16=2048, code31=546
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{5'd0,  10'sd100,  8'd10, 10'd125,  1'b0},   // R4, R3
    '{5'd0, -10'sd100,  8'd10, 10'd125,  1'b0},   // R2
    '{5'd31, 10'sd511,  8'd20, 10'd85,   1'b0},   // R3 slowest
    '{5'd9, -10'sd512,  8'd5,  10'd142,  1'b0},   // R2 most negative
    '{5'd0,  10'sd511,  8'd16, 10'd1022, 1'b0},   // R8 just below
    '{5'd0,  10'sd511,  8'd17, 10'd1023, 1'b1},   // R8 saturates
    '{5'd5,  10'sd0,    8'd30, 10'd0,    1'b0},   // R9 flag cleared, zero input
    '{5'd16, 10'sd256,  8'd50, 10'd400,  1'b0}    // R3 mid code
  };

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic openWin(logic [4:0] tc, logic withSample, logic signed [9:0] val);
    @(negedge clk);
    tcCode       = tc;
    intWindow    = 1'b1;
    sampleStrobe = withSample;
    sampleIn     = val;
    @(negedge clk);
    sampleStrobe = 1'b0;
  endtask

  task automatic pulse(logic signed [9:0] val);
    @(negedge clk);
    sampleIn     = val;
    sampleStrobe = 1'b1;
    @(negedge clk);
    sampleStrobe = 1'b0;
  endtask

  task automatic closeWin();
    @(negedge clk);
    intWindow = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset result", resultOut, 0);
    check("R1 reset clamp", clampFlag, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      openWin(VECS[i].tc, 1'b0, '0);
      check("R7 restart result", resultOut, 0);
      check("R9 clamp cleared at start", clampFlag, 0);
      repeat (int'(VECS[i].cnt)) pulse(VECS[i].smp);
      closeWin();
      check($sformatf("R4 vector %0d result", i), resultOut, int'(VECS[i].expRes));
      check($sformatf("R8 vector %0d clamp", i), clampFlag, int'(VECS[i].expClamp));
    end

    // R6: strobes while the window is low are ignored
    repeat (5) pulse(10'sd500);
    check("R6 hold result", resultOut, 400);
    check("R6 hold clamp", clampFlag, 0);

    // R8: long saturated window stays at the ceiling
    openWin(5'd0, 1'b0, '0);
    repeat (40) pulse(10'sd511);
    check("R8 ceiling result", resultOut, 1023);
    check("R9 sticky in window", clampFlag, 1);
    closeWin();
    repeat (3) pulse(10'sd100);
    check("R9 sticky in hold", clampFlag, 1);
    check("R6 hold after clamp", resultOut, 1023);

    // R10: code change mid-window ignored
    openWin(5'd0, 1'b0, '0);
    repeat (5) pulse(10'sd100);
    @(negedge clk);
    tcCode = 5'd31;
    repeat (5) pulse(10'sd100);
    closeWin();
    check("R10 mid-window code change", resultOut, 125);

    // R11: strobe in the start cycle counts on the reset level with the new code
    openWin(5'd0, 1'b1, -10'sd100);
    check("R11 start plus sample", resultOut, 12);
    repeat (9) pulse(10'sd100);
    closeWin();
    check("R11 window total", resultOut, 125);

    // R5: strobe-free cycles inside the window leave result unchanged
    openWin(5'd9, 1'b0, '0);
    pulse(-10'sd512);
    repeat (4) @(negedge clk);
    check("R5 no strobe no change", resultOut, 28);
    closeWin();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule